// File: doc/BRIEF.md
# Pipeline Inclusion Snoop Filter

This block sits beside an instruction cache with tree pseudo-LRU replacement and decides when every instruction still in flight is certain to be resident in that cache. While that holds, it raises one output, `filter_active`, which tells the existing detection logic for self-modifying code that an incoming store or snoop needs no pipeline check. This removes most false detections. The block reads only slow cache signals: LRU update strobes carrying the old and new replacement bits, eviction strobes with a set index, and two modular sequence tags for the youngest fetched and the most recently retired instruction.

Each set keeps a small saturating counter and one arm bit. The arm bit records that the set's LRU bits have changed since its last counted eviction. The eviction budget is log2(WAYS) counted evictions. An eviction that arrives when a set has used its whole budget saturates the filter. All per-set state then clears, the current fetch tag is captured, and the output stays low until the retirement tag reaches that captured tag.

Top module: `smc_incl_filter`

## Requirements
- R1: After a hard reset `filter_active` is 0. The fetch tag is captured at the first clock edge after reset. The output stays 0 until the drain rule of R5 is met for that captured tag.
- R2: An LRU update arms its set only when the old and new LRU bits differ. An update with equal old and new bits leaves the set unarmed.
- R3: An eviction in an armed set whose count is below the limit raises that count by one and disarms the set. An eviction in an unarmed set below the limit changes nothing.
- R4: An eviction in a set whose count equals the limit is a saturation. At that clock edge every set's count and arm bit are cleared, and `filter_active` is 0 from the following cycle.
- R5: A saturation captures `fetch_tag`. `filter_active` returns to 1 one cycle after a cycle in which `retire_tag - captured` (modulo 2^TAG_W) has its top bit clear, meaning the retirement tag has reached or passed the captured tag.
- R6: The drain comparison is wraparound safe. With a captured tag of 3 and TAG_W=8, retirement tags 250 and 2 do not complete the drain, and tag 3 does.
- R7: A saturation during a drain clears all sets again and replaces the captured tag with the newer fetch tag. An older retirement tag then no longer completes the drain.
- R8: The limit is log2(WAYS). With 8 ways, three counted evictions in a set keep the filter open, and the next eviction in that set saturates it.
- R9: When a saturation and a drain completion fall in the same cycle, the saturation wins and the output stays 0. When an LRU change and a counted eviction hit the same set in the same cycle, the set ends armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lru_upd_vld | input | 1 | LRU update strobe |
| lru_upd_set | input | SET_W | Set index of the LRU update |
| lru_old | input | WAYS-1 | LRU bits before the update |
| lru_new | input | WAYS-1 | LRU bits after the update |
| evict_vld | input | 1 | Eviction strobe |
| evict_set | input | SET_W | Set index of the eviction |
| fetch_tag | input | TAG_W | Sequence tag of the youngest fetched instruction |
| retire_tag | input | TAG_W | Sequence tag of the most recently retired instruction |
| filter_active | output | 1 | High while snoops may skip the pipeline inclusion check |

## Verification
Every result is registered once. A saturating eviction at one clock edge shows as a low `filter_active` just after that edge. A drain condition seen in one cycle raises the output just after the next edge. Count and arm updates have no direct output; they show up only in how many further evictions a set can take before the output drops. The bench drives each input set at the falling edge and samples one time unit after the rising edge. At that point it compares the output with a reference model that has been advanced by exactly that edge, so every expected value lines up with the cycle in which it is due.

// File: rtl/smc_incl_filter.sv
module smc_incl_filter #(
  parameter int SETS  = 16,
  parameter int WAYS  = 8,
  parameter int TAG_W = 8,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int LRU_W = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lru_upd_vld,
  input  logic [SET_W-1:0] lru_upd_set,
  input  logic [LRU_W-1:0] lru_old,
  input  logic [LRU_W-1:0] lru_new,
  input  logic             evict_vld,
  input  logic [SET_W-1:0] evict_set,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic [TAG_W-1:0] retire_tag,
  output logic             filter_active
);

  localparam int LIMIT = $clog2(WAYS);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q [SETS];
  logic [SETS-1:0]  armed_q;
  logic             draining_q;
  logic             need_cap_q;
  logic [TAG_W-1:0] cap_q;
  logic [TAG_W-1:0] lag;

  wire lru_moved = lru_upd_vld && (lru_old != lru_new);
  wire at_limit  = cnt_q[evict_set] == CNT_W'(LIMIT);
  wire sat       = evict_vld && at_limit;
  wire counted   = evict_vld && !at_limit && armed_q[evict_set];

  assign lag     = retire_tag - cap_q;
  wire   drained = draining_q && !need_cap_q && !lag[TAG_W-1];

  assign filter_active = !draining_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    wire hit_ev  = counted && (evict_set == SET_W'(s));
    wire hit_lru = lru_moved && (lru_upd_set == SET_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n || sat) cnt_q[s] <= '0;
      else if (hit_ev)   cnt_q[s] <= cnt_q[s] + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || sat) armed_q[s] <= 1'b0;
      else if (hit_lru)  armed_q[s] <= 1'b1;
      else if (hit_ev)   armed_q[s] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining_q <= 1'b1;
      need_cap_q <= 1'b1;
      cap_q      <= '0;
    end else if (sat) begin
      draining_q <= 1'b1;
      need_cap_q <= 1'b0;
      cap_q      <= fetch_tag;
    end else begin
      if (need_cap_q) begin
        cap_q      <= fetch_tag;
        need_cap_q <= 1'b0;
      end
      if (drained) draining_q <= 1'b0;
    end
  end

  // R4
  sat_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat |=> !filter_active);

  // R4
  sat_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat |=> (cnt_q[$past(evict_set)] == '0) && !armed_q[$past(evict_set)]);

  // R5
  cap_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat |=> cap_q == $past(fetch_tag));

  // R5
  open_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filter_active) |-> !$past(lag[TAG_W-1]) && !$past(sat));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_vld |-> cnt_q[evict_set] <= CNT_W'(LIMIT));

endmodule

// File: tb/smc_incl_filter_tb.sv
`timescale 1ns/1ps
module smc_incl_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv = 1'b0, ev = 1'b0;
  logic [3:0] us = '0, es = '0;
  logic [6:0] uo = '0, un = '0;
  logic [7:0] ft = '0, rt = '0;
  logic filter_active;

  int checks = 0, errors = 0;
  int m_cnt [16];
  bit m_armed [16];
  bit m_drain, m_need;
  logic [7:0] m_cap;

  always #5 clk = ~clk;

  smc_incl_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .lru_upd_vld(uv), .lru_upd_set(us), .lru_old(uo), .lru_new(un),
    .evict_vld(ev), .evict_set(es),
    .fetch_tag(ft), .retire_tag(rt),
    .filter_active(filter_active)
  );

  function automatic bit tag_reached(input logic [7:0] r, input logic [7:0] c);
    logic [7:0] d;
    d = r - c;
    return !d[7];
  endfunction

  task automatic check(input bit exp, input string rq);
    checks++;
    if (filter_active !== exp) begin
      errors++;
      $display("FAIL %s: filter_active=%b expected=%b at %0t", rq, filter_active, exp, $time);
    end
  endtask

  task automatic step(input logic nuv, input logic [3:0] nus, input logic [6:0] nuo,
                      input logic [6:0] nun, input logic nev, input logic [3:0] nes,
                      input string rq);
    bit sat, cnt_ok, drained, mv;
    @(negedge clk);
    uv = nuv; us = nus; uo = nuo; un = nun; ev = nev; es = nes;
    sat     = nev && m_cnt[nes] == 3;
    cnt_ok  = nev && m_cnt[nes] != 3 && m_armed[nes];
    drained = m_drain && !m_need && tag_reached(rt, m_cap);
    mv      = nuv && nuo != nun;
    @(posedge clk);
    #1;
    if (sat) begin
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_armed[i] = 0; end
      m_drain = 1; m_need = 0; m_cap = ft;
    end else begin
      if (cnt_ok) begin m_cnt[nes]++; m_armed[nes] = 0; end
      if (mv) m_armed[nus] = 1;
      if (m_need) begin m_cap = ft; m_need = 0; end
      else if (drained) m_drain = 0;
    end
    check(!m_drain, rq);
  endtask

  task automatic idle(input string rq);
    step(0, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic arm(input logic [3:0] s, input string rq);
    step(1, s, 7'h11, 7'h22, 0, 0, rq);
  endtask
  task automatic evict(input logic [3:0] s, input string rq);
    step(0, 0, 0, 0, 1, s, rq);
  endtask
  task automatic saturate(input logic [3:0] s, input string rq);
    for (int k = 0; k < 3; k++) begin arm(s, rq); evict(s, rq); end
    evict(s, rq);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    foreach (m_cnt[i]) begin m_cnt[i] = 0; m_armed[i] = 0; end
    m_drain = 1; m_need = 1; m_cap = 0;
    ft = 8'd10; rt = 8'd0;
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    #1 check(1'b0, "R1 after reset");
    idle("R1"); idle("R1");
    rt = 8'd9; idle("R1"); idle("R1");
    rt = 8'd10; idle("R1"); idle("R1");

    // R3: unarmed evictions do not count
    for (int k = 0; k < 6; k++) evict(4'd5, "R3");
    // R2: equal old/new bits do not arm
    step(1, 4'd5, 7'h33, 7'h33, 0, 0, "R2");
    evict(4'd5, "R2");
    evict(4'd5, "R2");
    // R8: three counted evictions keep filter open, fourth saturates
    ft = 8'd50;
    for (int k = 0; k < 3; k++) begin arm(4'd3, "R8"); evict(4'd3, "R8"); end
    arm(4'd3, "R8");
    evict(4'd3, "R4 R8 saturate");
    idle("R4");
    rt = 8'd49; idle("R5"); idle("R5");
    rt = 8'd50; idle("R5"); idle("R5");
    // R4: all sets cleared, set 3 takes a full budget again
    for (int k = 0; k < 3; k++) begin arm(4'd3, "R4"); evict(4'd3, "R4"); end

    // R6 wraparound
    ft = 8'd3;
    evict(4'd3, "R6 saturate");
    rt = 8'd250; idle("R6"); idle("R6");
    rt = 8'd2;   idle("R6"); idle("R6");
    rt = 8'd3;   idle("R6"); idle("R6");

    // R7 resaturation while draining
    ft = 8'd100; saturate(4'd7, "R7");
    ft = 8'd120; saturate(4'd8, "R7");
    rt = 8'd100; idle("R7"); idle("R7");
    rt = 8'd120; idle("R7"); idle("R7");

    // R9 saturation beats drain completion
    ft = 8'd140;
    saturate(4'd9, "R9");
    for (int k = 0; k < 3; k++) begin arm(4'd9, "R9"); evict(4'd9, "R9"); end
    rt = 8'd140; ft = 8'd160;
    evict(4'd9, "R9 sat wins");
    idle("R9");
    rt = 8'd160; idle("R9"); idle("R9");
    // R9 LRU change and counted eviction on same set leaves it armed
    arm(4'd2, "R9");
    step(1, 4'd2, 7'h01, 7'h02, 1, 4'd2, "R9 same cycle");
    evict(4'd2, "R9"); evict(4'd2, "R9 armed kept");
    idle("R9");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] s1, s2;
      logic [6:0] o, nw;
      s1 = 4'($urandom_range(0, 3));
      s2 = 4'($urandom_range(0, 3));
      o  = 7'($urandom_range(0, 3));
      nw = 7'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) ft = ft + 8'($urandom_range(0, 4));
      if ($urandom_range(0, 2) == 0) rt = rt + 8'($urandom_range(0, 3));
      if (tag_reached(rt, ft) && rt != ft) rt = ft;
      step(1'($urandom_range(0, 1)), s1, o, nw, 1'($urandom_range(0, 2) == 0), s2, "R3 R4 R5 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule